// File: doc/BRIEF.md
# Half-Bridge PWM Input Decoder

This block takes the high-side and low-side command inputs of three half-bridges and decodes them into gate enables for the upper and lower switch of each bridge. For each phase it also reports the intended state of the switch node: driven high, driven low or floating. A 2-bit mode input selects how the commands are read.

In independent mode, every phase has its own high and low command. A request that turns on exactly one switch is passed to that gate. A request for both switches is turned into a floating phase. In complementary mode, the low command acts as an output enable and the high command picks the level.

All command and mode inputs pass through a two-flop synchronizer before they are decoded. Every output therefore follows its inputs after exactly two clock edges. Dead time, analog drive and current sensing belong to other blocks.

Top module: `hbd_pwm_decoder`

## Requirements
- R1: Each output reflects the `mode_sel`, `cmd_hi` and `cmd_lo` values sampled two rising clock edges earlier. After only one edge, the outputs still show the previous decode.
- R2: While `rst` is high, and for the first two edges after it falls, every gate output is 0 and every node field reads floating.
- R3: With `mode_sel` = 2'b00, a phase with high command 0 and low command 0 has both gates off and a floating node.
- R4: With `mode_sel` = 2'b00, a phase with high command 1 and low command 0 turns on only its high gate, and its node reads high.
- R5: With `mode_sel` = 2'b00, a phase with high command 0 and low command 1 turns on only its low gate, and its node reads low.
- R6: With `mode_sel` = 2'b00, a phase with both commands at 1 has both gates off and a floating node.
- R7: With `mode_sel` = 2'b01, a phase whose low command is 0 has both gates off and a floating node, whatever its high command is.
- R8: With `mode_sel` = 2'b01 and the low command at 1, a high command of 1 turns on only the high gate (node high), and a high command of 0 turns on only the low gate (node low).
- R9: With `mode_sel` = 2'b10 or 2'b11, every gate is off and every node reads floating.
- R10: The two gates of a phase are never on in the same cycle. Each phase's 2-bit node field in `node_state` is encoded as 2'b00 floating, 2'b01 low and 2'b10 high, and it always agrees with that phase's gates.
- R11: Each phase decodes only its own commands. Phase p uses `cmd_hi[p]` and `cmd_lo[p]`, and its node field is `node_state[2p+1:2p]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Decode mode: 00 independent, 01 complementary, 10/11 all off |
| cmd_hi | input | NUM_PHASES | Per-phase high command |
| cmd_lo | input | NUM_PHASES | Per-phase low command (enable in complementary mode) |
| gate_hi | output | NUM_PHASES | High-side gate enable per phase |
| gate_lo | output | NUM_PHASES | Low-side gate enable per phase |
| node_state | output | 2*NUM_PHASES | Intended switch-node state, 2 bits per phase |

## Verification
The decode assertions compare each output with the port values sampled two edges earlier. They therefore assume that the inputs were sampled cleanly at the clock, and that a two-cycle history exists since reset. A warm-up counter holds these checks off until that history exists. The bench changes inputs only on falling edges and holds each pattern for at least two rising edges before it samples, so every sampled value matches what the assertions expect. Sweeping every combination of mode and commands across the three phases covers both decode tables and the mixed-phase cases without any glitching stimulus.

// File: rtl/hbd_pkg.sv
package hbd_pkg;

    localparam int SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        MODE_INDEP = 2'b00,
        MODE_COMPL = 2'b01,
        MODE_RSV2  = 2'b10,
        MODE_RSV3  = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        NODE_FLOAT = 2'b00,
        NODE_LOW   = 2'b01,
        NODE_HIGH  = 2'b10
    } node_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } phase_cmd_t;

    typedef struct packed {
        logic  gh;
        logic  gl;
        node_e node;
    } phase_out_t;

    localparam phase_out_t OUT_OFF  = '{gh: 1'b0, gl: 1'b0, node: NODE_FLOAT};
    localparam phase_out_t OUT_HIGH = '{gh: 1'b1, gl: 1'b0, node: NODE_HIGH};
    localparam phase_out_t OUT_LOW  = '{gh: 1'b0, gl: 1'b1, node: NODE_LOW};

    function automatic phase_out_t decode_phase(mode_e m, phase_cmd_t c);
        phase_out_t r;
        r = OUT_OFF;
        unique case (m)
            MODE_INDEP: begin
                if (c.hi && !c.lo)      r = OUT_HIGH;
                else if (c.lo && !c.hi) r = OUT_LOW;
                else                    r = OUT_OFF;
            end
            MODE_COMPL: begin
                if (!c.lo)     r = OUT_OFF;
                else if (c.hi) r = OUT_HIGH;
                else           r = OUT_LOW;
            end
            default: r = OUT_OFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/hbd_sync.sv
module hbd_sync #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [DEPTH];

    genvar i;
    generate
        for (i = 0; i < DEPTH; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= '0;
                else if (i == 0) stg[i] <= d;
                else stg[i] <= stg[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q = stg[DEPTH-1];
endmodule

// File: rtl/hbd_phase_dec.sv
module hbd_phase_dec
    import hbd_pkg::*;
(
    input  mode_e      mode,
    input  phase_cmd_t cmd,
    output logic       gh,
    output logic       gl,
    output logic [1:0] node
);
    phase_out_t res;

    always_comb begin
        res  = decode_phase(mode, cmd);
        gh   = res.gh;
        gl   = res.gl;
        node = res.node;
    end
endmodule

// File: rtl/hbd_pwm_decoder.sv
module hbd_pwm_decoder
    import hbd_pkg::*;
#(
    parameter int NUM_PHASES = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [1:0]              mode_sel,
    input  logic [NUM_PHASES-1:0]   cmd_hi,
    input  logic [NUM_PHASES-1:0]   cmd_lo,
    output logic [NUM_PHASES-1:0]   gate_hi,
    output logic [NUM_PHASES-1:0]   gate_lo,
    output logic [2*NUM_PHASES-1:0] node_state
);
    localparam int SW = 2 + 2*NUM_PHASES;
    localparam int WW = $clog2(SYNC_DEPTH + 1);

    logic [SW-1:0]         raw_in, syn_out;
    logic [NUM_PHASES-1:0] s_hi, s_lo;
    mode_e                 s_mode;

    assign raw_in = {mode_sel, cmd_hi, cmd_lo};

    hbd_sync #(.WIDTH(SW), .DEPTH(SYNC_DEPTH)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (syn_out)
    );

    assign s_mode = mode_e'(syn_out[SW-1 -: 2]);
    assign s_hi   = syn_out[2*NUM_PHASES-1 -: NUM_PHASES];
    assign s_lo   = syn_out[NUM_PHASES-1:0];

    // Warm-up count so the decode checks see a full history since reset
    logic [WW-1:0] warm_cnt;
    logic          warm;
    always_ff @(posedge clk) begin
        if (rst) warm_cnt <= '0;
        else if (warm_cnt != WW'(SYNC_DEPTH)) warm_cnt <= warm_cnt + 1'b1;
    end
    assign warm = (warm_cnt == WW'(SYNC_DEPTH));

    genvar p;
    generate
        for (p = 0; p < NUM_PHASES; p++) begin : g_ph
            phase_cmd_t pc;
            assign pc = '{hi: s_hi[p], lo: s_lo[p]};

            hbd_phase_dec u_dec (
                .mode (s_mode),
                .cmd  (pc),
                .gh   (gate_hi[p]),
                .gl   (gate_lo[p]),
                .node (node_state[2*p +: 2])
            );

            AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
                !(gate_hi[p] && gate_lo[p])); // R10
            AST_NODE_MATCHES_GATES: assert property (@(posedge clk) disable iff (rst)
                ((node_state[2*p +: 2] == 2'b10) == gate_hi[p]) &&
                ((node_state[2*p +: 2] == 2'b01) == gate_lo[p])); // R10
            AST_RSVD_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
                (warm && $past(mode_sel[1], 2)) |-> (!gate_hi[p] && !gate_lo[p])); // R9
            AST_INDEP_BOTH_FLOATS: assert property (@(posedge clk) disable iff (rst)
                (warm && $past(mode_sel, 2) == 2'b00 && $past(cmd_hi[p], 2) && $past(cmd_lo[p], 2))
                |-> (node_state[2*p +: 2] == 2'b00)); // R6
            AST_COMPL_DISABLED_FLOATS: assert property (@(posedge clk) disable iff (rst)
                (warm && $past(mode_sel, 2) == 2'b01 && !$past(cmd_lo[p], 2))
                |-> (!gate_hi[p] && !gate_lo[p])); // R7
        end
    endgenerate

endmodule

// File: tb/sim_hbd_pwm_decoder.sv
module sim_hbd_pwm_decoder;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode_sel = 2'b00;
    logic [NP-1:0] cmd_hi = '0, cmd_lo = '0;
    logic [NP-1:0] gate_hi, gate_lo;
    logic [2*NP-1:0] node_state;

    int vectors = 0;
    int fails   = 0;

    always #2 clk = ~clk; // 250 MHz

    hbd_pwm_decoder #(.NUM_PHASES(NP)) u0 (
        .clk(clk), .rst(rst), .mode_sel(mode_sel),
        .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .node_state(node_state)
    );

    // expected {gh, gl, node[1:0]} from the requirement tables
    function automatic logic [3:0] model(logic [1:0] m, logic h, logic l);
        case (m)
            2'b00: model = (h && !l) ? 4'b1010 : (l && !h) ? 4'b0101 : 4'b0000;
            2'b01: model = !l ? 4'b0000 : (h ? 4'b1010 : 4'b0101);
            default: model = 4'b0000;
        endcase
    endfunction

    function automatic string tag(logic [1:0] m, logic h, logic l);
        if (m[1]) return "R9";
        if (m == 2'b01) return l ? "R8" : "R7";
        case ({h, l})
            2'b00: return "R3";
            2'b10: return "R4";
            2'b01: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic cmp(string req, logic [3:0] act, logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b (mode=%b hi=%b lo=%b)",
                     req, act, exp, mode_sel, cmd_hi, cmd_lo);
        end
    endtask

    task automatic check_phases(logic [1:0] m, logic [NP-1:0] h, logic [NP-1:0] l, string ovr);
        for (int p = 0; p < NP; p++) begin
            logic [3:0] act;
            act = {gate_hi[p], gate_lo[p], node_state[2*p +: 2]};
            cmp((ovr != "") ? ovr : tag(m, h[p], l[p]), act, model(m, h[p], l[p]));
            vectors++;
            if (gate_hi[p] && gate_lo[p]) begin
                fails++;
                $display("FAIL R10: phase %0d actual gh=1 gl=1 expected not both", p);
            end
        end
    endtask

    task automatic apply(logic [1:0] m, logic [NP-1:0] h, logic [NP-1:0] l);
        @(negedge clk);
        mode_sel = m; cmd_hi = h; cmd_lo = l;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        // R2: inputs request high drive, reset holds all off
        mode_sel = 2'b00; cmd_hi = '1; cmd_lo = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_phases(2'b11, '0, '0, "R2");
        rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check_phases(2'b11, '0, '0, "R2");
        @(posedge clk); @(negedge clk);
        check_phases(2'b00, '1, '0, "R4");
    endtask

    task automatic t_lag;
        // R1: exactly two edges of latency
        apply(2'b00, 3'b000, 3'b111);
        @(negedge clk);
        mode_sel = 2'b00; cmd_hi = 3'b111; cmd_lo = 3'b000;
        @(posedge clk); @(negedge clk);
        check_phases(2'b00, 3'b000, 3'b111, "R1");
        @(posedge clk); @(negedge clk);
        check_phases(2'b00, 3'b111, 3'b000, "R1");
        @(negedge clk);
        mode_sel = 2'b11;
        @(posedge clk); @(negedge clk);
        check_phases(2'b00, 3'b111, 3'b000, "R1");
        @(posedge clk); @(negedge clk);
        check_phases(2'b11, 3'b111, 3'b000, "R1");
    endtask

    task automatic t_sweep(logic [1:0] m);
        for (int h = 0; h < 8; h++)
            for (int l = 0; l < 8; l++) begin
                apply(m, h[NP-1:0], l[NP-1:0]);
                check_phases(m, h[NP-1:0], l[NP-1:0], "");
            end
    endtask

    task automatic t_mixed;
        // R11: each phase follows only its own pair
        apply(2'b00, 3'b001, 3'b010);
        check_phases(2'b00, 3'b001, 3'b010, "R11");
        apply(2'b01, 3'b100, 3'b110);
        check_phases(2'b01, 3'b100, 3'b110, "R11");
    endtask

    initial begin
        #(4 * 200000);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_lag();
        t_sweep(2'b00);
        t_sweep(2'b01);
        t_sweep(2'b10);
        t_sweep(2'b11);
        t_mixed();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule